// File: doc/BRIEF.md
# Dual-Clock Token-Ring FIFO

This block moves data words from a writer running on one clock to a reader running on an unrelated clock. Storage is a ring of cells. The writer owns a one-hot write token and the reader owns a one-hot read token. Each token steps to the next cell only when its own operation completes. The ring needs no binary or Gray-coded pointers.

Each cell records whether it is occupied. A put flips a bit kept in the write domain, and a get flips a matching bit kept in the read domain. The cell is occupied when the two bits differ. Each side copies the other side's per-cell bits through a two-flop synchronizer, so the metastability wait falls on the flag path and never on the data path. A synchronized copy can only lag, so each side sees cells as fuller (writer) or emptier (reader) than they really are. The writer's full flag and the reader's empty flag are both taken at the cell under that side's own token.

A request made while its side's flag is raised is dropped. The read data bus is combinational. It carries the word only during a cycle in which a get is performed, and it is zero at all other times. The valid output is tied high, because a performed get always returns a stored word.

Top module: `ring_fifo_mc`

## Requirements
- R1: After reset the write-side full flag is 0, the read-side empty flag is 1, and both tokens sit at cell 0.
- R2: Words leave in the order they were accepted, with none lost and none duplicated, for any pattern of requests on either side and any ratio between the two clocks.
- R3: With no gets, full rises after exactly CELLS accepted puts. A put requested while full is high is not stored and does not advance the write token.
- R4: A get requested while empty is high returns zero on the read data bus, consumes nothing and does not advance the read token.
- R5: The valid output is always 1.
- R6: The read data bus is zero in every read-clock cycle in which no get is performed.
- R7: When the FIFO is empty, a word written by one put becomes visible to the reader on the second read-clock edge after that put: empty stays 1 after the first such edge and falls after the second.
- R8: When the FIFO is full, a cell freed by one get becomes usable by the writer on the second write-clock edge after that get: full stays 1 after the first such edge and falls after the second.
- R9: Each token is one-hot at all times, moves one cell per performed operation, and wraps from the last cell back to cell 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| putClk | input | 1 | Write-side clock |
| putRstN | input | 1 | Write-side asynchronous reset, active low |
| putReq | input | 1 | Request to store putData on this edge |
| putData | input | DW | Word to store |
| putFull | output | 1 | No free cell at the write token; requests are dropped |
| getClk | input | 1 | Read-side clock |
| getRstN | input | 1 | Read-side asynchronous reset, active low |
| getReq | input | 1 | Request to take the word at the read token on this edge |
| getData | output | DW | Word being taken this cycle; zero otherwise |
| getValid | output | 1 | Constant 1 |
| getEmpty | output | 1 | No stored word at the read token; requests are dropped |

## Verification
The bench goes after the two flag-latency edges. If a side used the other side's bits without synchronizing them, empty would fall one edge early (R7) or full would fall one edge early (R8). If a side kept an extra stage, the flag would fall one edge late. Puts held high while full, carrying a marker word, catch a write token that moves or a cell that is overwritten while blocked: the drained sequence would show a gap or the marker. Gets held high while empty catch a read token that moves without a word to take: later words would come out shifted by one cell. A sweep of request throttling on both sides at three read-clock ratios covers the ring several times over, and a design that wraps badly or loses a flag update would reorder, drop or repeat words.

// File: rtl/ringfifo_pkg.sv
`timescale 1ns/100ps
package ringfifo_pkg;
  // synchronizer depth on every flag path between the two clock domains
  localparam int unsigned SYNC_STAGES = 2;

  // which end of the ring a token engine drives
  typedef enum logic {
    SIDE_PUT = 1'b0,
    SIDE_GET = 1'b1
  } side_e;
endpackage

// File: rtl/rf_sync.sv
`timescale 1ns/100ps
module rf_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = ringfifo_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < int'(STAGES); s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rf_side.sv
`timescale 1ns/100ps
module rf_side #(
  parameter int unsigned         CELLS = 8,
  parameter ringfifo_pkg::side_e SIDE  = ringfifo_pkg::SIDE_PUT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic [CELLS-1:0] peerTgl,
  output logic [CELLS-1:0] ownTgl,
  output logic [CELLS-1:0] tok,
  output logic             flag,
  output logic             opEn
);
  logic [CELLS-1:0] peerSync;
  logic [CELLS-1:0] occView;
  logic             tokOcc;

  rf_sync #(.W(CELLS), .STAGES(ringfifo_pkg::SYNC_STAGES)) u_peerSync (
    .clk (clk),
    .rstN(rstN),
    .d   (peerTgl),
    .q   (peerSync)
  );

  // a cell is occupied when the put and get toggles disagree
  assign occView = ownTgl ^ peerSync;
  assign tokOcc  = |(tok & occView);

  generate
    if (SIDE == ringfifo_pkg::SIDE_PUT) begin : g_putFlag
      assign flag = tokOcc;
    end else begin : g_getFlag
      assign flag = ~tokOcc;
    end
  endgenerate

  assign opEn = req & ~flag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tok    <= CELLS'(1);
      ownTgl <= '0;
    end else if (opEn) begin
      tok    <= {tok[CELLS-2:0], tok[CELLS-1]};
      ownTgl <= ownTgl ^ tok;
    end
  end

  // R9
  tok_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(tok));

  // R9
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opEn |=> $stable(tok));

  // R9
  tgl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opEn |=> $stable(ownTgl));
endmodule

// File: rtl/rf_ctrl.sv
`timescale 1ns/100ps
module rf_ctrl #(
  parameter int unsigned CELLS = 8
) (
  input  logic               putClk,
  input  logic               putRstN,
  input  logic               putReq,
  output logic               putFull,
  input  logic               getClk,
  input  logic               getRstN,
  input  logic               getReq,
  output logic               getEmpty,
  output logic [2*CELLS-1:0] strbBus
);
  typedef struct packed {
    logic [CELLS-1:0] wrSel;
    logic [CELLS-1:0] rdSel;
  } strobe_t;

  strobe_t          strb;
  logic [CELLS-1:0] putTgl, getTgl, putTok, getTok;
  logic             putEn, getEn;

  rf_side #(.CELLS(CELLS), .SIDE(ringfifo_pkg::SIDE_PUT)) u_putSide (
    .clk    (putClk),
    .rstN   (putRstN),
    .req    (putReq),
    .peerTgl(getTgl),
    .ownTgl (putTgl),
    .tok    (putTok),
    .flag   (putFull),
    .opEn   (putEn)
  );

  rf_side #(.CELLS(CELLS), .SIDE(ringfifo_pkg::SIDE_GET)) u_getSide (
    .clk    (getClk),
    .rstN   (getRstN),
    .req    (getReq),
    .peerTgl(putTgl),
    .ownTgl (getTgl),
    .tok    (getTok),
    .flag   (getEmpty),
    .opEn   (getEn)
  );

  assign strb.wrSel = putTok & {CELLS{putEn}};
  assign strb.rdSel = getTok & {CELLS{getEn}};
  assign strbBus    = strb;

  // R3
  put_blocked_chk: assert property (@(posedge putClk) disable iff (!putRstN)
    putFull |-> (strb.wrSel == '0));

  // R4
  get_blocked_chk: assert property (@(posedge getClk) disable iff (!getRstN)
    getEmpty |-> (strb.rdSel == '0));
endmodule

// File: rtl/rf_dpath.sv
`timescale 1ns/100ps
module rf_dpath #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CELLS = 8
) (
  input  logic               putClk,
  input  logic               putRstN,
  input  logic               getClk,
  input  logic               getRstN,
  input  logic [DW-1:0]      putData,
  input  logic [2*CELLS-1:0] strbBus,
  output logic [DW-1:0]      getData
);
  typedef struct packed {
    logic [CELLS-1:0] wrSel;
    logic [CELLS-1:0] rdSel;
  } strobe_t;

  strobe_t     strb;
  logic [DW-1:0] cellWord [CELLS];

  assign strb = strbBus;

  generate
    for (genvar c = 0; c < int'(CELLS); c++) begin : g_cell
      always_ff @(posedge putClk) begin
        if (strb.wrSel[c]) cellWord[c] <= putData;
      end
    end
  endgenerate

  always_comb begin
    getData = '0;
    for (int c = 0; c < int'(CELLS); c++) begin
      if (strb.rdSel[c]) getData = getData | cellWord[c];
    end
  end

  // R9
  wr_onehot0_chk: assert property (@(posedge putClk) disable iff (!putRstN)
    $onehot0(strb.wrSel));

  // R6
  rd_onehot0_chk: assert property (@(posedge getClk) disable iff (!getRstN)
    $onehot0(strb.rdSel));
endmodule

// File: rtl/ring_fifo_mc.sv
`timescale 1ns/100ps
module ring_fifo_mc #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CELLS = 8
) (
  input  logic          putClk,
  input  logic          putRstN,
  input  logic          putReq,
  input  logic [DW-1:0] putData,
  output logic          putFull,
  input  logic          getClk,
  input  logic          getRstN,
  input  logic          getReq,
  output logic [DW-1:0] getData,
  output logic          getValid,
  output logic          getEmpty
);
  localparam int unsigned STRB_W = 2 * CELLS;

  logic [STRB_W-1:0] strbBus;

  rf_ctrl #(.CELLS(CELLS)) u_ctrl (
    .putClk  (putClk),
    .putRstN (putRstN),
    .putReq  (putReq),
    .putFull (putFull),
    .getClk  (getClk),
    .getRstN (getRstN),
    .getReq  (getReq),
    .getEmpty(getEmpty),
    .strbBus (strbBus)
  );

  rf_dpath #(.DW(DW), .CELLS(CELLS)) u_dpath (
    .putClk (putClk),
    .putRstN(putRstN),
    .getClk (getClk),
    .getRstN(getRstN),
    .putData(putData),
    .strbBus(strbBus),
    .getData(getData)
  );

  assign getValid = 1'b1;
endmodule

// File: tb/ring_fifo_mc_tb.sv
`timescale 1ns/100ps
module ring_fifo_mc_tb;
  localparam int DW    = 8;
  localparam int CELLS = 8;

  logic          putClk = 1'b0, getClk = 1'b0;
  logic          putRstN = 1'b0, getRstN = 1'b0;
  logic          putReq = 1'b0, getReq = 1'b0;
  logic [DW-1:0] putData = '0;
  logic          putFull, getValid, getEmpty;
  logic [DW-1:0] getData;

  realtime getHalf = 5.5;
  int nChk = 0, nBad = 0;
  int wrIdx = 0, rdIdx = 0;

  ring_fifo_mc #(.DW(DW), .CELLS(CELLS)) u_dut (
    .putClk(putClk), .putRstN(putRstN), .putReq(putReq), .putData(putData),
    .putFull(putFull), .getClk(getClk), .getRstN(getRstN), .getReq(getReq),
    .getData(getData), .getValid(getValid), .getEmpty(getEmpty)
  );

  // 125 MHz write clock; read clock period is an odd multiple of 1 ns
  // so its rising edges never meet the write clock's rising edges
  always #4 putClk = ~putClk;
  initial forever begin
    #(getHalf) getClk = ~getClk;
  end

  function automatic logic [DW-1:0] wordOf(int i);
    return DW'((i * 29 + 7) ^ (i >> 3));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic putWords(int n, int pat);
    bit acc = 0;
    int cyc = 0;
    forever begin
      @(negedge putClk);
      if (acc) wrIdx++;
      acc = 0;
      if (wrIdx >= n) break;
      putReq  = ((cyc % (pat + 1)) == 0);
      putData = wordOf(wrIdx);
      cyc++;
      acc = putReq && !putFull;
    end
    putReq = 1'b0;
  endtask

  task automatic getWords(int n, int pat);
    bit take = 0;
    int cyc = 0;
    forever begin
      @(negedge getClk);
      if (take) rdIdx++;
      take = 0;
      if (rdIdx >= n) break;
      getReq = ((cyc % (pat + 1)) == 0);
      cyc++;
      #0.1;
      chk(getValid == 1'b1, "R5", 32'(getValid), 32'd1);
      if (getReq && !getEmpty) begin
        // R2 R9: order across ring wraps
        chk(getData == wordOf(rdIdx), "R2 R9", 32'(getData), 32'(wordOf(rdIdx)));
        take = 1;
      end else begin
        chk(getData == '0, "R6", 32'(getData), 32'd0);
      end
    end
    getReq = 1'b0;
  endtask

  initial begin
    #1_500_000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    realtime halves [3] = '{5.5, 3.5, 9.5};
    #30;
    putRstN = 1'b1;
    getRstN = 1'b1;
    #2;
    // R1
    chk(putFull == 1'b0, "R1", 32'(putFull), 32'd0);
    chk(getEmpty == 1'b1, "R1", 32'(getEmpty), 32'd1);
    chk(getValid == 1'b1, "R5", 32'(getValid), 32'd1);
    chk(getData == '0, "R6", 32'(getData), 32'd0);

    // R7: visibility delay of a single word
    @(negedge putClk);
    putReq = 1'b1; putData = wordOf(0);
    @(posedge putClk); #0.1;
    putReq = 1'b0; wrIdx = 1;
    chk(getEmpty == 1'b1, "R7", 32'(getEmpty), 32'd1);
    @(posedge getClk); #0.1;
    chk(getEmpty == 1'b1, "R7", 32'(getEmpty), 32'd1);
    @(posedge getClk); #0.1;
    chk(getEmpty == 1'b0, "R7", 32'(getEmpty), 32'd0);
    getWords(1, 0);

    // R3: fill with the reader idle
    repeat (4) @(negedge putClk);
    for (int k = 0; k < CELLS; k++) begin
      @(negedge putClk);
      chk(putFull == 1'b0, "R3", 32'(putFull), 32'd0);
      putReq = 1'b1; putData = wordOf(wrIdx);
      @(posedge putClk); #0.1;
      putReq = 1'b0; wrIdx++;
    end
    @(negedge putClk);
    chk(putFull == 1'b1, "R3", 32'(putFull), 32'd1);
    putReq = 1'b1; putData = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge putClk);
      chk(putFull == 1'b1, "R3", 32'(putFull), 32'd1);
    end
    putReq = 1'b0;

    // R8: release delay of one freed cell
    @(negedge getClk);
    getReq = 1'b1; #0.1;
    chk(getData == wordOf(rdIdx), "R2", 32'(getData), 32'(wordOf(rdIdx)));
    @(posedge getClk); #0.1;
    getReq = 1'b0; rdIdx++;
    chk(putFull == 1'b1, "R8", 32'(putFull), 32'd1);
    @(posedge putClk); #0.1;
    chk(putFull == 1'b1, "R8", 32'(putFull), 32'd1);
    @(posedge putClk); #0.1;
    chk(putFull == 1'b0, "R8", 32'(putFull), 32'd0);
    getWords(wrIdx, 0);

    // R4: gets while empty must not consume or disturb the read token
    for (int k = 0; k < 4; k++) begin
      @(negedge getClk);
      getReq = 1'b1; #0.1;
      chk(getEmpty == 1'b1, "R4", 32'(getEmpty), 32'd1);
      chk(getData == '0, "R4", 32'(getData), 32'd0);
    end
    getReq = 1'b0;
    putWords(wrIdx + 1, 0);
    getWords(wrIdx, 0);

    // R2: throttle sweep at three read-clock ratios
    for (int c = 0; c < 3; c++) begin
      getHalf = halves[c];
      for (int wp = 0; wp < 3; wp++) begin
        for (int rp = 0; rp < 3; rp++) begin
          int target = wrIdx + 3 * CELLS + 3;
          fork
            putWords(target, wp);
            getWords(target, rp);
          join
          @(negedge getClk); #0.1;
          chk(getEmpty == 1'b1, "R2", 32'(getEmpty), 32'd1);
          chk(rdIdx == wrIdx, "R2", 32'(rdIdx), 32'(wrIdx));
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule